// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block holds a small table of 2-bit saturating counters and uses them to guess whether a conditional branch will be taken. A fetch stage presents a branch address with a lookup strobe. One cycle later the block returns a registered direction guess. When the branch later resolves, the execute stage presents the same address, a resolve strobe and the real outcome. The block then trains the addressed counter.

On every resolve the block also reports two results, both registered. The first is the number of stall cycles the pipeline must charge: zero when the counter's guess was right, and a fixed two-cycle penalty when it was wrong. The second is a one-cycle jump marker whenever the resolved branch was taken, which a downstream hazard unit uses to track redirected fetch.

Instructions are halfword aligned, so address bit 0 carries no information and is dropped. The table entry is taken from the address bits just above it. The table size parameter must be a power of two of at least 4.

Top module: `bp2_dir_predictor`

## Requirements
- R1: After synchronous reset every counter holds the value 1, so any lookup predicts not-taken, and all outputs are 0 while reset is held.
- R2: The entry for an address `pc` is `(pc & (TABLE_SIZE-1)) >> 1`. Addresses that differ only in bit 0, or only in bits at or above log2(TABLE_SIZE), share an entry. Addresses that differ in any bit from 1 up to log2(TABLE_SIZE)-1 use separate entries.
- R3: A counter predicts taken exactly when its bit 1 is set (values 2 and 3), and not-taken for values 0 and 1.
- R4: A resolve with outcome taken (`resolve_taken`=1) raises the counter by one, and a counter at 3 stays at 3.
- R5: A resolve with outcome not-taken lowers the counter by one, and a counter at 0 stays at 0.
- R6: One cycle after a resolve, `res_valid_o` is 1. `penalty_o` is 2 if the outcome differs from the guess of the counter value held before that update, and 0 otherwise. In cycles with no resolve, `res_valid_o` and `penalty_o` are 0.
- R7: `jump_o` is 1 for exactly the cycle following a resolve whose outcome is taken, and 0 in every other cycle.
- R8: When a lookup and a resolve address the same entry in the same cycle, the lookup returns the guess of the counter after that update.
- R9: `pred_valid_o` is 1 exactly one cycle after a cycle with `lookup_valid`=1. `pred_taken_o` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Request a direction guess this cycle |
| lookup_pc | input | PC_W | Branch address to look up |
| resolve_valid | input | 1 | A branch resolves this cycle |
| resolve_pc | input | PC_W | Address of the resolving branch |
| resolve_taken | input | 1 | Real outcome: 1 taken, 0 not-taken |
| pred_valid_o | output | 1 | Guess available (one cycle after lookup) |
| pred_taken_o | output | 1 | Guessed direction, 1 means taken |
| res_valid_o | output | 1 | Resolve results available |
| penalty_o | output | PEN_W | Stall cycles charged for the resolved branch (0 or 2) |
| jump_o | output | 1 | Marker pulse for a taken branch, toward hazard logic |

## Verification
The bench builds the block with TABLE_SIZE = 8 and PC_W = 16. This gives only four entries, indexed by address bits 2:1. Address 0x8 then aliases 0x0, while 0x2, 0x4 and 0x6 each land in their own entry, so aliasing above the index field and separation inside it can both be seen with a handful of addresses. The small table also lets one entry be driven to both saturation limits and back in a short run, and lets a lookup and a resolve be aimed at the same entry in one cycle.

// File: rtl/bp2_pkg.sv
package bp2_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd1;
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;

  function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_MAX) nxt = cur + 2'd1;
    end else begin
      if (cur != CTR_MIN) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

  function automatic logic ctr_guess(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp2_index.sv
module bp2_index #(
  parameter int PC_W       = 32,
  parameter int TABLE_SIZE = 16,
  localparam int IDX_W     = $clog2(TABLE_SIZE) - 1
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);

  localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(TABLE_SIZE - 1);

  assign idx = IDX_W'((pc & ADDR_MASK) >> 1);

endmodule

// File: rtl/bp2_counter_table.sv
module bp2_counter_table
  import bp2_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  output ctr_t             wr_cur_ctr
);

  ctr_t ctr_q [ENTRIES];
  ctr_t wr_next;

  assign wr_cur_ctr = ctr_q[wr_idx];
  assign wr_next    = ctr_train(ctr_q[wr_idx], wr_taken);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        ctr_q[g] <= CTR_RESET;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        ctr_q[g] <= wr_next;
      end
    end
  end

  always_comb begin
    if (wr_en && (wr_idx == rd_idx)) begin
      rd_ctr = wr_next;
    end else begin
      rd_ctr = ctr_q[rd_idx];
    end
  end

endmodule

// File: rtl/bp2_resolve_unit.sv
module bp2_resolve_unit
  import bp2_pkg::*;
#(
  parameter int MISS_PENALTY = 2,
  localparam int PEN_W       = $clog2(MISS_PENALTY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rs_valid,
  input  logic             rs_taken,
  input  ctr_t             rs_ctr,
  output logic             res_valid_o,
  output logic [PEN_W-1:0] penalty_o,
  output logic             jump_o
);

  logic miss;

  assign miss = (ctr_guess(rs_ctr) != rs_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      penalty_o   <= '0;
      jump_o      <= 1'b0;
    end else begin
      res_valid_o <= rs_valid;
      penalty_o   <= (rs_valid && miss) ? PEN_W'(MISS_PENALTY) : '0;
      jump_o      <= rs_valid && rs_taken;
    end
  end

endmodule

// File: rtl/bp2_dir_predictor.sv
module bp2_dir_predictor
  import bp2_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int TABLE_SIZE   = 16,
  parameter int MISS_PENALTY = 2,
  localparam int ENTRIES     = TABLE_SIZE / 2,
  localparam int IDX_W       = $clog2(ENTRIES),
  localparam int PEN_W       = $clog2(MISS_PENALTY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lookup_valid,
  input  logic [PC_W-1:0]  lookup_pc,
  input  logic             resolve_valid,
  input  logic [PC_W-1:0]  resolve_pc,
  input  logic             resolve_taken,
  output logic             pred_valid_o,
  output logic             pred_taken_o,
  output logic             res_valid_o,
  output logic [PEN_W-1:0] penalty_o,
  output logic             jump_o
);

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] rs_idx;
  ctr_t             lk_ctr;
  ctr_t             rs_ctr;

  bp2_index #(.PC_W(PC_W), .TABLE_SIZE(TABLE_SIZE)) u_lk_index (
    .pc  (lookup_pc),
    .idx (lk_idx)
  );

  bp2_index #(.PC_W(PC_W), .TABLE_SIZE(TABLE_SIZE)) u_rs_index (
    .pc  (resolve_pc),
    .idx (rs_idx)
  );

  bp2_counter_table #(.ENTRIES(ENTRIES)) u_table (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (resolve_valid),
    .wr_idx     (rs_idx),
    .wr_taken   (resolve_taken),
    .rd_idx     (lk_idx),
    .rd_ctr     (lk_ctr),
    .wr_cur_ctr (rs_ctr)
  );

  bp2_resolve_unit #(.MISS_PENALTY(MISS_PENALTY)) u_resolve (
    .clk         (clk),
    .rst         (rst),
    .rs_valid    (resolve_valid),
    .rs_taken    (resolve_taken),
    .rs_ctr      (rs_ctr),
    .res_valid_o (res_valid_o),
    .penalty_o   (penalty_o),
    .jump_o      (jump_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid_o <= 1'b0;
      pred_taken_o <= 1'b0;
    end else begin
      pred_valid_o <= lookup_valid;
      pred_taken_o <= lookup_valid && ctr_guess(lk_ctr);
    end
  end

endmodule

// File: rtl/bp2_checker.sv
module bp2_checker #(
  parameter int PEN_W        = 2,
  parameter int MISS_PENALTY = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             lookup_valid,
  input logic             resolve_valid,
  input logic             resolve_taken,
  input logic             pred_valid_o,
  input logic             res_valid_o,
  input logic [PEN_W-1:0] penalty_o,
  input logic             jump_o
);

  // R9: a guess appears exactly one cycle after a lookup
  a_r9_pred_after_lookup: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> pred_valid_o);

  a_r9_no_pred_without_lookup: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> !pred_valid_o);

  // R7: a taken resolve yields a jump marker next cycle
  a_r7_jump_on_taken: assert property (@(posedge clk) disable iff (rst)
    (resolve_valid && resolve_taken) |=> jump_o);

  a_r7_no_jump_otherwise: assert property (@(posedge clk) disable iff (rst)
    !(resolve_valid && resolve_taken) |=> !jump_o);

  // R6: penalty is zero or the fixed miss value, and zero without a resolve
  a_r6_penalty_range: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (penalty_o == '0 || penalty_o == PEN_W'(MISS_PENALTY)));

  a_r6_penalty_idle: assert property (@(posedge clk) disable iff (rst)
    !resolve_valid |=> (!res_valid_o && penalty_o == '0));

endmodule

bind bp2_dir_predictor bp2_checker #(
  .PEN_W(PEN_W),
  .MISS_PENALTY(MISS_PENALTY)
) u_bp2_checker (
  .clk           (clk),
  .rst           (rst),
  .lookup_valid  (lookup_valid),
  .resolve_valid (resolve_valid),
  .resolve_taken (resolve_taken),
  .pred_valid_o  (pred_valid_o),
  .res_valid_o   (res_valid_o),
  .penalty_o     (penalty_o),
  .jump_o        (jump_o)
);

// File: tb/bp2_dir_predictor_test.sv
module bp2_dir_predictor_test;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 16;
  localparam int TS         = 8;
  localparam int NENT       = TS / 2;
  localparam int PEN_W      = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lookup_valid = 1'b0;
  logic [PC_W-1:0]  lookup_pc = '0;
  logic             resolve_valid = 1'b0;
  logic [PC_W-1:0]  resolve_pc = '0;
  logic             resolve_taken = 1'b0;
  logic             pred_valid_o;
  logic             pred_taken_o;
  logic             res_valid_o;
  logic [PEN_W-1:0] penalty_o;
  logic             jump_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct { logic taken; string tag; } pred_item_t;
  typedef struct { logic [PEN_W-1:0] pen; logic jmp; string tag; } res_item_t;

  pred_item_t pq[$];
  res_item_t  rq[$];
  int         mdl[NENT];

  always #(CLK_PERIOD/2) clk = ~clk;

  bp2_dir_predictor #(.PC_W(PC_W), .TABLE_SIZE(TS), .MISS_PENALTY(2)) uut (
    .clk           (clk),
    .rst           (rst),
    .lookup_valid  (lookup_valid),
    .lookup_pc     (lookup_pc),
    .resolve_valid (resolve_valid),
    .resolve_pc    (resolve_pc),
    .resolve_taken (resolve_taken),
    .pred_valid_o  (pred_valid_o),
    .pred_taken_o  (pred_taken_o),
    .res_valid_o   (res_valid_o),
    .penalty_o     (penalty_o),
    .jump_o        (jump_o)
  );

  function automatic int ent_of(input logic [PC_W-1:0] pc);
    return int'((pc & PC_W'(TS - 1)) >> 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: drive one cycle of stimulus and push the expected results
  task automatic step(input logic lv, input logic [PC_W-1:0] lpc,
                      input logic rv, input logic [PC_W-1:0] rpc,
                      input logic rt, input string tag);
    @(negedge clk);
    lookup_valid  = lv;
    lookup_pc     = lpc;
    resolve_valid = rv;
    resolve_pc    = rpc;
    resolve_taken = rt;
    if (rv) begin
      res_item_t r;
      int e;
      e = ent_of(rpc);
      r.pen = ((mdl[e] >= 2) != rt) ? PEN_W'(2) : PEN_W'(0);
      r.jmp = rt;
      r.tag = tag;
      rq.push_back(r);
      if (rt) begin
        if (mdl[e] < 3) mdl[e]++;
      end else begin
        if (mdl[e] > 0) mdl[e]--;
      end
    end
    if (lv) begin
      pred_item_t p;
      p.taken = (mdl[ent_of(lpc)] >= 2);
      p.tag   = tag;
      pq.push_back(p);
    end
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, '0, 1'b0, "idle");
  endtask

  // monitor: compare outputs just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (pred_valid_o) begin
          if (pq.size() == 0) begin
            check(1'b0, "R9 unexpected pred_valid_o", 1, 0);
          end else begin
            pred_item_t p;
            p = pq.pop_front();
            check(pred_taken_o == p.taken, p.tag, int'(pred_taken_o), int'(p.taken));
          end
        end else if (pq.size() != 0) begin
          pred_item_t p;
          p = pq.pop_front();
          check(1'b0, {"R9 missing guess for ", p.tag}, 0, 1);
        end
        if (res_valid_o) begin
          if (rq.size() == 0) begin
            check(1'b0, "R6 unexpected res_valid_o", 1, 0);
          end else begin
            res_item_t r;
            r = rq.pop_front();
            check(penalty_o == r.pen, {r.tag, " R6 penalty"}, int'(penalty_o), int'(r.pen));
            check(jump_o == r.jmp, {r.tag, " R7 jump"}, int'(jump_o), int'(r.jmp));
          end
        end else begin
          if (rq.size() != 0) begin
            res_item_t r;
            r = rq.pop_front();
            check(1'b0, {"R6 missing result for ", r.tag}, 0, 1);
          end
          if (jump_o || penalty_o != '0)
            check(1'b0, "R7 jump/penalty without resolve", int'(jump_o), 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) mdl[i] = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    check(!pred_valid_o && !pred_taken_o && !res_valid_o && penalty_o == '0 && !jump_o,
          "R1 outputs in reset", int'(pred_valid_o | res_valid_o | jump_o), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: every entry starts weakly not-taken
    step(1'b1, 16'h0000, 1'b0, '0, 1'b0, "R1 entry0");
    step(1'b1, 16'h0002, 1'b0, '0, 1'b0, "R1 entry1");
    step(1'b1, 16'h0004, 1'b0, '0, 1'b0, "R1 entry2");
    step(1'b1, 16'h0006, 1'b0, '0, 1'b0, "R1 entry3");

    // R4 and R3: train entry 0 up to saturation
    step(1'b0, '0, 1'b1, 16'h0000, 1'b1, "R4 inc 1to2 miss");
    step(1'b0, '0, 1'b1, 16'h0000, 1'b1, "R4 inc 2to3 hit");
    step(1'b0, '0, 1'b1, 16'h0000, 1'b1, "R4 sat at 3");
    step(1'b1, 16'h0000, 1'b0, '0, 1'b0, "R3 value3 taken");

    // R2: aliasing and separation
    step(1'b1, 16'h0001, 1'b0, '0, 1'b0, "R2 bit0 dropped");
    step(1'b1, 16'h0008, 1'b0, '0, 1'b0, "R2 high alias");
    step(1'b1, 16'hFFF8, 1'b0, '0, 1'b0, "R2 high alias2");
    step(1'b1, 16'h0002, 1'b0, '0, 1'b0, "R2 bit1 separate");

    // R4/R5: come back down from 3 (saturation kept it at 3, not 0)
    step(1'b1, 16'h0000, 1'b1, 16'h0008, 1'b0, "R5 dec 3to2");
    step(1'b1, 16'h0000, 1'b1, 16'h0001, 1'b0, "R5 dec 2to1");

    // R5: saturate entry 2 at 0, then climb
    step(1'b0, '0, 1'b1, 16'h0004, 1'b0, "R5 dec 1to0");
    step(1'b0, '0, 1'b1, 16'h0004, 1'b0, "R5 sat at 0");
    step(1'b0, '0, 1'b1, 16'h0004, 1'b1, "R5 inc 0to1");
    step(1'b1, 16'h0004, 1'b0, '0, 1'b0, "R3 value1 not-taken");
    step(1'b0, '0, 1'b1, 16'h0004, 1'b1, "R4 inc 1to2");
    step(1'b1, 16'h0004, 1'b0, '0, 1'b0, "R3 value2 taken");

    // R8: same entry lookup and update in one cycle
    step(1'b1, 16'h0006, 1'b1, 16'h0006, 1'b1, "R8 bypass up");
    step(1'b1, 16'h0006, 1'b1, 16'h0006, 1'b0, "R8 bypass down");
    step(1'b1, 16'h0004, 1'b1, 16'h0002, 1'b1, "R8 other entry");

    // R9/R7: back to back mixed traffic
    step(1'b1, 16'h0002, 1'b1, 16'h0002, 1'b1, "R7 taken pulse");
    step(1'b0, '0, 1'b1, 16'h0002, 1'b0, "R7 not-taken no pulse");
    idle();
    step(1'b1, 16'h0002, 1'b0, '0, 1'b0, "R9 isolated lookup");
    idle();
    idle();
    idle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule